// File: doc/BRIEF.md
# Load-Store Dependence Predictor with Shared Set Identifiers

This block tells the dispatch stage whether a memory instruction should wait for an older store. It keeps two small direct-mapped tables. The first maps an instruction address to a set identifier. The second maps a set identifier to the tag of the newest store that has been dispatched in that set.

When a load and a store are reported as having collided, both are put into the same set, so every store a load has ever collided with ends up sharing one identifier. A load in a set that has an outstanding last store is told to wait, and it is given that store's tag. A store in such a set waits on the previous store of its set, which keeps the stores of one set in program order. The store then becomes the new last store of the set.

When a store issues, it removes itself from the second table, but only if the entry still holds its own tag. Address comparison, violation detection, recovery and the issue queue lie outside this block.

Top module: `store_set_predictor`

## Requirements
- R1: After reset no instruction address belongs to any set, no set has a last store, and the identifier allocator starts at 0. Every lookup therefore reports no set and no wait.
- R2: The address table is indexed by pc[PC_LSB+IDX_W-1:PC_LSB] (bits [7:2] by default). Two addresses that agree in those bits share one entry.
- R3: On a training request where neither the load nor the store address has a valid entry, both get the allocator's current identifier. The allocator then advances by one, modulo 2^ID_W.
- R4: On a training request where exactly one of the two addresses has a valid entry, the other address is given that entry's identifier, and the allocator does not move.
- R5: On a training request where both addresses have valid entries, both are set to the smaller of the two identifiers.
- R6: A store dispatched with a valid set records its tag as the last store of that set. A later load or store lookup in that set reports wait=1, with dep_tag equal to the recorded tag.
- R7: A lookup whose address has no valid entry, or whose set holds no last store, reports wait=0 and dep_tag=0. set_id reads 0 whenever in_set=0.
- R8: A store issue invalidates the last-store entry of its set only if that entry holds the issuing tag. With any other tag the entry is unchanged.
- R9: A store dispatch write and an issue invalidate to the same set in the same cycle leave the dispatched store recorded.
- R10: ssit_clr invalidates every address entry and overrides training in the same cycle. lfst_clr invalidates every last-store entry and overrides a dispatch write in the same cycle.
- R11: Lookup outputs are combinational and reflect the table state before this cycle's updates. All lookup outputs are 0 while lkp_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ssit_clr | input | 1 | Invalidate all address-table entries |
| lfst_clr | input | 1 | Invalidate all last-store entries |
| lkp_valid | input | 1 | Dispatch lookup request |
| lkp_is_store | input | 1 | Lookup is for a store |
| lkp_pc | input | PC_W | Address of the dispatched instruction |
| lkp_tag | input | TAG_W | Instruction tag of a dispatched store |
| lkp_in_set | output | 1 | Instruction belongs to a set |
| lkp_set_id | output | ID_W | Its set identifier |
| lkp_wait | output | 1 | Instruction must wait for a store |
| lkp_dep_tag | output | TAG_W | Tag of the store to wait for |
| iss_valid | input | 1 | A store issues |
| iss_pc | input | PC_W | Issuing store's address |
| iss_tag | input | TAG_W | Issuing store's tag |
| trn_valid | input | 1 | Violation training request |
| trn_ld_pc | input | PC_W | Address of the violating load |
| trn_st_pc | input | PC_W | Address of the violating store |

## Verification
The checker watches, on every cycle, that a wait is never reported outside a set and that idle lookups read zero. It also checks that the allocator advances exactly on a fresh-set training request, and that either clear leaves nothing behind on the next cycle. Several behaviours only show up in the bench's scenarios, which compare against a behavioural model every clock: the choice among new, joined and merged identifiers, address aliasing, the tag-match rule on issue, and the dispatch-over-issue priority.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  typedef enum logic [1:0] {
    TRN_FRESH = 2'd0,
    TRN_JOIN_LD = 2'd1,
    TRN_JOIN_ST = 2'd2,
    TRN_MERGE = 2'd3
  } trn_kind_e;

  function automatic trn_kind_e trn_classify(input logic ld_known, input logic st_known);
    case ({ld_known, st_known})
      2'b00:   return TRN_FRESH;
      2'b10:   return TRN_JOIN_LD;
      2'b01:   return TRN_JOIN_ST;
      default: return TRN_MERGE;
    endcase
  endfunction
endpackage

// File: rtl/ssp_id_alloc.sv
module ssp_id_alloc #(
  parameter int ID_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  output logic [ID_W-1:0] next_id
);
  logic [ID_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else if (take) cnt_q <= cnt_q + 1'b1;
  end

  assign next_id = cnt_q;
endmodule

// File: rtl/ssp_ssit.sv
module ssp_ssit
  import ssp_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 6,
  parameter int ID_W   = 4,
  parameter int PC_LSB = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic [PC_W-1:0] rd_a_pc,
  output logic            rd_a_vld,
  output logic [ID_W-1:0] rd_a_id,
  input  logic [PC_W-1:0] rd_b_pc,
  output logic            rd_b_vld,
  output logic [ID_W-1:0] rd_b_id,
  input  logic            trn_valid,
  input  logic [PC_W-1:0] trn_ld_pc,
  input  logic [PC_W-1:0] trn_st_pc,
  input  logic [ID_W-1:0] alloc_id,
  output logic            alloc_take
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0] vld_q;
  logic [ID_W-1:0]  id_q [DEPTH];

  function automatic logic [IDX_W-1:0] pc_index(input logic [PC_W-1:0] pc);
    return pc[PC_LSB +: IDX_W];
  endfunction

  function automatic logic [ID_W-1:0] lower_id(input logic [ID_W-1:0] a, input logic [ID_W-1:0] b);
    return (a < b) ? a : b;
  endfunction

  logic [IDX_W-1:0] a_idx, b_idx, ld_idx, st_idx;
  logic             ld_known, st_known, trn_go;
  logic [ID_W-1:0]  ld_id, st_id, new_id;
  trn_kind_e        kind;
  logic             unused_pc;

  assign unused_pc = ^{rd_a_pc, rd_b_pc, trn_ld_pc, trn_st_pc};

  always_comb begin
    a_idx    = pc_index(rd_a_pc);
    b_idx    = pc_index(rd_b_pc);
    ld_idx   = pc_index(trn_ld_pc);
    st_idx   = pc_index(trn_st_pc);
    ld_known = vld_q[ld_idx];
    st_known = vld_q[st_idx];
    ld_id    = id_q[ld_idx];
    st_id    = id_q[st_idx];
    kind     = trn_classify(ld_known, st_known);
    case (kind)
      TRN_FRESH:   new_id = alloc_id;
      TRN_JOIN_LD: new_id = ld_id;
      TRN_JOIN_ST: new_id = st_id;
      default:     new_id = lower_id(ld_id, st_id);
    endcase
  end

  assign trn_go     = trn_valid && !clr;
  assign alloc_take = trn_go && (kind == TRN_FRESH);

  assign rd_a_vld = vld_q[a_idx];
  assign rd_a_id  = rd_a_vld ? id_q[a_idx] : '0;
  assign rd_b_vld = vld_q[b_idx];
  assign rd_b_id  = rd_b_vld ? id_q[b_idx] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      vld_q <= '0;
    end else if (trn_go) begin
      vld_q[ld_idx] <= 1'b1;
      vld_q[st_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (trn_go) begin
      id_q[ld_idx] <= new_id;
      id_q[st_idx] <= new_id;
    end
  end
endmodule

// File: rtl/ssp_lfst.sv
module ssp_lfst #(
  parameter int ID_W  = 4,
  parameter int TAG_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [ID_W-1:0]  rd_id,
  output logic             rd_vld,
  output logic [TAG_W-1:0] rd_tag,
  input  logic             wr_en,
  input  logic [ID_W-1:0]  wr_id,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             inv_en,
  input  logic [ID_W-1:0]  inv_id,
  input  logic [TAG_W-1:0] inv_tag,
  output logic             inv_fire
);
  localparam int SETS = 1 << ID_W;

  logic [SETS-1:0]  vld_q;
  logic [TAG_W-1:0] tag_q [SETS];
  logic             inv_hit, wr_same;

  assign inv_hit  = inv_en && vld_q[inv_id] && (tag_q[inv_id] == inv_tag);
  assign wr_same  = wr_en && (wr_id == inv_id);
  assign inv_fire = inv_hit && !wr_same && !clr;

  assign rd_vld = vld_q[rd_id];
  assign rd_tag = rd_vld ? tag_q[rd_id] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      vld_q <= '0;
    end else begin
      if (inv_fire) vld_q[inv_id] <= 1'b0;
      if (wr_en)    vld_q[wr_id]  <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !clr) tag_q[wr_id] <= wr_tag;
  end
endmodule

// File: rtl/store_set_predictor.sv
module store_set_predictor #(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 6,
  parameter int ID_W   = 4,
  parameter int TAG_W  = 6,
  parameter int PC_LSB = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ssit_clr,
  input  logic             lfst_clr,
  input  logic             lkp_valid,
  input  logic             lkp_is_store,
  input  logic [PC_W-1:0]  lkp_pc,
  input  logic [TAG_W-1:0] lkp_tag,
  output logic             lkp_in_set,
  output logic [ID_W-1:0]  lkp_set_id,
  output logic             lkp_wait,
  output logic [TAG_W-1:0] lkp_dep_tag,
  input  logic             iss_valid,
  input  logic [PC_W-1:0]  iss_pc,
  input  logic [TAG_W-1:0] iss_tag,
  input  logic             trn_valid,
  input  logic [PC_W-1:0]  trn_ld_pc,
  input  logic [PC_W-1:0]  trn_st_pc
);
  logic             a_vld, b_vld, l_vld;
  logic [ID_W-1:0]  a_id, b_id, alloc_id;
  logic [TAG_W-1:0] l_tag;
  logic             alloc_take, st_record, iss_lookup, iss_retire;

  ssp_id_alloc #(.ID_W(ID_W)) u_alloc (
    .clk(clk), .rst_n(rst_n), .take(alloc_take), .next_id(alloc_id)
  );

  ssp_ssit #(.PC_W(PC_W), .IDX_W(IDX_W), .ID_W(ID_W), .PC_LSB(PC_LSB)) u_ssit (
    .clk(clk), .rst_n(rst_n), .clr(ssit_clr),
    .rd_a_pc(lkp_pc), .rd_a_vld(a_vld), .rd_a_id(a_id),
    .rd_b_pc(iss_pc), .rd_b_vld(b_vld), .rd_b_id(b_id),
    .trn_valid(trn_valid), .trn_ld_pc(trn_ld_pc), .trn_st_pc(trn_st_pc),
    .alloc_id(alloc_id), .alloc_take(alloc_take)
  );

  assign st_record  = lkp_valid && lkp_is_store && a_vld;
  assign iss_lookup = iss_valid && b_vld;

  ssp_lfst #(.ID_W(ID_W), .TAG_W(TAG_W)) u_lfst (
    .clk(clk), .rst_n(rst_n), .clr(lfst_clr),
    .rd_id(a_id), .rd_vld(l_vld), .rd_tag(l_tag),
    .wr_en(st_record), .wr_id(a_id), .wr_tag(lkp_tag),
    .inv_en(iss_lookup), .inv_id(b_id), .inv_tag(iss_tag),
    .inv_fire(iss_retire)
  );

  assign lkp_in_set  = lkp_valid && a_vld;
  assign lkp_set_id  = lkp_in_set ? a_id : '0;
  assign lkp_wait    = lkp_in_set && l_vld;
  assign lkp_dep_tag = lkp_wait ? l_tag : '0;
endmodule

// File: rtl/ssp_checker.sv
module ssp_checker #(
  parameter int ID_W  = 4,
  parameter int TAG_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ssit_clr,
  input logic             lfst_clr,
  input logic             lkp_valid,
  input logic             lkp_in_set,
  input logic             lkp_wait,
  input logic [TAG_W-1:0] lkp_dep_tag,
  input logic             alloc_take,
  input logic [ID_W-1:0]  alloc_id
);
  AST_WAIT_NEEDS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_wait |-> lkp_in_set); // R7

  AST_IDLE_LOOKUP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !lkp_valid |-> (!lkp_in_set && !lkp_wait && lkp_dep_tag == '0)); // R11

  AST_ALLOC_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_take |=> (alloc_id == ID_W'($past(alloc_id) + 1'b1))); // R3

  AST_ALLOC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !alloc_take |=> $stable(alloc_id)); // R4

  AST_PC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ssit_clr |=> !lkp_in_set); // R10

  AST_LAST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    lfst_clr |=> !lkp_wait); // R10
endmodule

bind store_set_predictor ssp_checker #(.ID_W(ID_W), .TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ssit_clr(ssit_clr), .lfst_clr(lfst_clr),
  .lkp_valid(lkp_valid), .lkp_in_set(lkp_in_set), .lkp_wait(lkp_wait),
  .lkp_dep_tag(lkp_dep_tag), .alloc_take(alloc_take), .alloc_id(alloc_id)
);

// File: tb/sim_store_set_predictor.sv
module sim_store_set_predictor;
  localparam int PC_W = 32, IDX_W = 6, ID_W = 4, TAG_W = 6, PC_LSB = 2;
  localparam int NSETS = 1 << ID_W;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, ssit_clr, lfst_clr, lkp_valid, lkp_is_store, iss_valid, trn_valid;
  logic [PC_W-1:0] lkp_pc, iss_pc, trn_ld_pc, trn_st_pc;
  logic [TAG_W-1:0] lkp_tag, iss_tag, lkp_dep_tag;
  logic lkp_in_set, lkp_wait;
  logic [ID_W-1:0] lkp_set_id;

  store_set_predictor #(.PC_W(PC_W), .IDX_W(IDX_W), .ID_W(ID_W), .TAG_W(TAG_W), .PC_LSB(PC_LSB)) u0 (
    .clk(clk), .rst_n(rst_n), .ssit_clr(ssit_clr), .lfst_clr(lfst_clr),
    .lkp_valid(lkp_valid), .lkp_is_store(lkp_is_store), .lkp_pc(lkp_pc), .lkp_tag(lkp_tag),
    .lkp_in_set(lkp_in_set), .lkp_set_id(lkp_set_id), .lkp_wait(lkp_wait), .lkp_dep_tag(lkp_dep_tag),
    .iss_valid(iss_valid), .iss_pc(iss_pc), .iss_tag(iss_tag),
    .trn_valid(trn_valid), .trn_ld_pc(trn_ld_pc), .trn_st_pc(trn_st_pc)
  );

  int checks = 0, fails = 0;
  string req = "R1";
  bit done = 0;

  // Behavioural model: key present = entry valid.
  int m_set[int];
  int m_last[int];
  int m_ctr = 0;

  function automatic int idx_of(logic [PC_W-1:0] pc);
    return int'((pc >> PC_LSB) % (1 << IDX_W));
  endfunction

  task automatic check(string r, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", r, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    int i;
    bit in_s, w;
    int sid, dep;
    i = idx_of(lkp_pc);
    in_s = lkp_valid && m_set.exists(i);
    sid = in_s ? m_set[i] : 0;
    w = in_s && m_last.exists(sid);
    dep = w ? m_last[sid] : 0;
    check(req, "in_set", int'(lkp_in_set), int'(in_s));
    check(req, "set_id", int'(lkp_set_id), sid);
    check(req, "wait", int'(lkp_wait), int'(w));
    check(req, "dep_tag", int'(lkp_dep_tag), dep);
  endtask

  task automatic model_update();
    int li, si, ii, li2, lid, sid, nid;
    bit lk, sk, wr, inv;
    li = idx_of(lkp_pc);
    ii = idx_of(iss_pc);
    wr = lkp_valid && lkp_is_store && m_set.exists(li);
    lid = wr ? m_set[li] : -1;
    inv = iss_valid && m_set.exists(ii) && m_last.exists(m_set[ii]) &&
          (m_last[m_set[ii]] == int'(iss_tag)) && !(wr && lid == m_set[ii]);
    sid = inv ? m_set[ii] : -1;
    if (lfst_clr) m_last.delete();
    else begin
      if (inv) m_last.delete(sid);
      if (wr) m_last[lid] = int'(lkp_tag);
    end
    if (ssit_clr) m_set.delete();
    else if (trn_valid) begin
      li2 = idx_of(trn_ld_pc);
      si = idx_of(trn_st_pc);
      lk = m_set.exists(li2);
      sk = m_set.exists(si);
      if (!lk && !sk) begin nid = m_ctr; m_ctr = (m_ctr + 1) % NSETS; end
      else if (lk && !sk) nid = m_set[li2];
      else if (!lk && sk) nid = m_set[si];
      else nid = (m_set[li2] < m_set[si]) ? m_set[li2] : m_set[si];
      m_set[li2] = nid;
      m_set[si] = nid;
    end
  endtask

  task automatic tick();
    #1;
    compare();
    @(posedge clk);
    model_update();
    @(negedge clk);
    ssit_clr = 0; lfst_clr = 0; lkp_valid = 0; lkp_is_store = 0;
    iss_valid = 0; trn_valid = 0;
  endtask

  task automatic look(logic [PC_W-1:0] pc, bit st, int tag);
    lkp_valid = 1; lkp_is_store = st; lkp_pc = pc; lkp_tag = TAG_W'(tag);
  endtask
  task automatic issue(logic [PC_W-1:0] pc, int tag);
    iss_valid = 1; iss_pc = pc; iss_tag = TAG_W'(tag);
  endtask
  task automatic train(logic [PC_W-1:0] ld, logic [PC_W-1:0] st);
    trn_valid = 1; trn_ld_pc = ld; trn_st_pc = st;
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; ssit_clr = 0; lfst_clr = 0; lkp_valid = 0; lkp_is_store = 0;
    iss_valid = 0; trn_valid = 0; lkp_pc = '0; iss_pc = '0; trn_ld_pc = '0;
    trn_st_pc = '0; lkp_tag = '0; iss_tag = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    req = "R1"; look(32'h1000, 0, 0); tick();
    req = "R1"; look(32'h1004, 1, 3); tick();

    req = "R3"; train(32'h1000, 32'h1004); tick();
    req = "R3"; look(32'h1000, 0, 0); #1;
    check("R3", "fresh id", int'(lkp_set_id), 0); tick();

    req = "R6"; look(32'h1004, 1, 5); tick();
    req = "R6"; look(32'h1000, 0, 0); #1;
    check("R6", "load dep", int'(lkp_dep_tag), 5); tick();
    req = "R6"; look(32'h1004, 1, 7); #1;
    check("R6", "store waits on prior", int'(lkp_dep_tag), 5); tick();

    req = "R8"; issue(32'h1004, 5); tick();
    req = "R8"; look(32'h1000, 0, 0); #1;
    check("R8", "mismatch keeps", int'(lkp_dep_tag), 7); tick();
    req = "R8"; issue(32'h1004, 7); tick();
    req = "R7"; look(32'h1000, 0, 0); #1;
    check("R7", "no last store", int'(lkp_wait), 0); tick();

    req = "R4"; train(32'h1008, 32'h1004); tick();
    req = "R4"; look(32'h1008, 0, 0); #1;
    check("R4", "joined id", int'(lkp_set_id), 0); tick();
    req = "R3"; train(32'h100c, 32'h1010); tick();
    req = "R3"; look(32'h1010, 0, 0); #1;
    check("R3", "second id", int'(lkp_set_id), 1); tick();
    req = "R5"; train(32'h1000, 32'h1010); tick();
    req = "R5"; look(32'h1010, 0, 0); #1;
    check("R5", "merge st", int'(lkp_set_id), 0); tick();
    req = "R5"; train(32'h1014, 32'h1018); tick();
    req = "R5"; train(32'h1014, 32'h1004); tick();
    req = "R5"; look(32'h1014, 0, 0); #1;
    check("R5", "merge ld", int'(lkp_set_id), 0); tick();

    req = "R2"; look(32'h1100, 0, 0); #1;
    check("R2", "alias shares", int'(lkp_in_set), 1); tick();

    req = "R9"; look(32'h1004, 1, 20); tick();
    req = "R9"; look(32'h1008, 1, 9); issue(32'h1004, 20); tick();
    req = "R9"; look(32'h1000, 0, 0); #1;
    check("R9", "dispatch wins", int'(lkp_dep_tag), 9); tick();

    req = "R10"; lfst_clr = 1; look(32'h1004, 1, 11); tick();
    req = "R10"; look(32'h1000, 0, 0); #1;
    check("R10", "last cleared", int'(lkp_wait), 0); tick();
    req = "R10"; ssit_clr = 1; train(32'h1020, 32'h1024); tick();
    req = "R10"; look(32'h1020, 0, 0); #1;
    check("R10", "pc cleared", int'(lkp_in_set), 0); tick();

    req = "R11"; tick();

    req = "R11";
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(0, 2) != 0)
        look(32'h1000 + 32'($urandom_range(0, 7) * 4) + 32'($urandom_range(0, 1) * 256),
             1'($urandom_range(0, 1)), int'($urandom_range(0, 63)));
      if ($urandom_range(0, 3) == 0)
        issue(32'h1000 + 32'($urandom_range(0, 7) * 4), int'($urandom_range(0, 63)));
      if ($urandom_range(0, 9) == 0)
        train(32'h1000 + 32'($urandom_range(0, 15) * 4), 32'h1000 + 32'($urandom_range(0, 15) * 4));
      if ($urandom_range(0, 199) == 0) ssit_clr = 1;
      if ($urandom_range(0, 99) == 0) lfst_clr = 1;
      tick();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule